// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

This block holds recently used page translations for a 32-bit virtual address space with 4 KB pages. A lookup presents a virtual address together with the access type (load or store) and the privilege level (user or kernel). The page number is compared against every stored translation at once, and within the same cycle the block returns either a hit with the physical address, formed from the stored physical page number and the untouched 12-bit offset, or a request to the external page walker to fetch the missing translation.

Each slot stores a valid flag, read, write and user-access permissions, a dirty flag, the virtual page tag and the physical page number. Each hit is checked against the permissions, and a denied access raises a protection fault. A permitted store to a clean page raises a dirty-update request and marks the slot dirty. The walker returns a translation through a fill port. The fill lands in the lowest-numbered empty slot, or, if every slot is valid, in a victim chosen by a round-robin pointer or by a free-running LFSR, depending on a parameter. A flush input empties the whole array in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: A lookup (`lkp_valid_i`=1) hits when any valid slot's tag equals `lkp_vaddr_i[31:12]`; all `ENTRIES` slots (default 32) are compared in the same cycle, and `hit_o` is combinational from the lookup inputs.
- R2: A fill (`fill_valid_i`=1) stores tag, physical page number and the read, write, user and dirty flags into one slot, and the new translation is visible to lookups from the next cycle on.
- R3: On a hit `paddr_o` equals `{ppn, lkp_vaddr_i[11:0]}`; with no hit `paddr_o` is zero.
- R4: A valid lookup with no hit drives `walk_req_o`=1 with `walk_vpn_o`=`lkp_vaddr_i[31:12]`; `walk_req_o` and `hit_o` are never high together, and both are low when no lookup is presented.
- R5: A hit raises `prot_fault_o` when a load meets a clear read flag, a store meets a clear write flag, or a user-mode access (`lkp_user_i`=1) meets a clear user flag; kernel accesses ignore the user flag. Only a hit can fault.
- R6: A permitted store that hits a slot with a clear dirty flag drives `dirty_req_o`=1 and sets that slot's dirty flag at the clock edge, so a later store to the same page raises no request; loads and faulting stores never raise it.
- R7: While any slot is invalid, a fill goes to the lowest-numbered invalid slot and evicts nothing.
- R8: With the round-robin policy (`REPL`=0, default) and all slots valid, successive fills evict slots 0, 1, 2, ... in turn, wrapping at `ENTRIES`; the pointer starts at 0 after reset and moves only on such evictions.
- R9: With the LFSR policy (`REPL`=1) and all slots valid, a fill evicts exactly one resident translation, picked from a free-running LFSR.
- R10: `flush_i`=1 makes every slot invalid at the next edge, and it overrides a fill or dirty update in the same cycle.
- R11: After reset every slot is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all slots |
| lkp_valid_i | input | 1 | Lookup present |
| lkp_vaddr_i | input | VA_W | Virtual address of lookup |
| lkp_store_i | input | 1 | 1 = store, 0 = load |
| lkp_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| hit_o | output | 1 | Translation found |
| paddr_o | output | PA_W | Translated physical address |
| walk_req_o | output | 1 | Miss, refill requested |
| walk_vpn_o | output | VA_W-PAGE_W | Page number to walk |
| prot_fault_o | output | 1 | Access denied |
| dirty_req_o | output | 1 | First permitted store to a clean page |
| fill_valid_i | input | 1 | Refill write |
| fill_vpn_i | input | VA_W-PAGE_W | Refill tag |
| fill_ppn_i | input | PA_W-PAGE_W | Refill physical page number |
| fill_rd_i | input | 1 | Refill read permission |
| fill_wr_i | input | 1 | Refill write permission |
| fill_usr_i | input | 1 | Refill user-access permission |
| fill_dirty_i | input | 1 | Refill dirty flag |

## Verification
Directed patterns fill the array without loss (telling invalid-first placement apart from premature eviction), then force evictions in a fixed order so that a stale round-robin pointer or a wrong victim shows up as the wrong page missing. A permission grid crosses load/store and user/kernel with every flag combination, which separates the three fault causes and shows that kernel mode ignores the user flag. A random phase then works a page pool larger than the array, with random permissions, dirty states and occasional flushes, and compares hit, address, walk request, fault and dirty request each cycle against a bench model. A second instance with the LFSR policy is checked only on the count of resident pages after each eviction, since its victim cannot be predicted.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
  typedef struct packed {
    logic vld;
    logic rd;
    logic wr;
    logic usr;
    logic dty;
  } pte_flags_t;

  localparam int unsigned REPL_FIFO = 0;
  localparam int unsigned REPL_LFSR = 1;
endpackage

// File: rtl/tlb_fa_match.sv
module tlb_fa_match #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              vpn_i,
  output logic [ENTRIES-1:0]            match_o,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == vpn_i);
  end

  assign any_o = |match_o;

  // OR-encoder; tags are unique so at most one bit is set
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/tlb_fa_victim.sv
module tlb_fa_victim #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned REPL    = 0,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               use_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] free_idx, ptr_q, pick;
  logic             have_free;
  logic [15:0]      lfsr_q;

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_i[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
  end

  assign pick  = (REPL == tlb_fa_pkg::REPL_LFSR) ? lfsr_q[IDX_W-1:0] : ptr_q;
  assign idx_o = have_free ? free_idx : pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      lfsr_q <= 16'hACE1;
    end else begin
      lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
      if (use_i && !have_free) ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_fa_prot.sv
module tlb_fa_prot
  import tlb_fa_pkg::*;
(
  input  logic       hit_i,
  input  pte_flags_t flg_i,
  input  logic       store_i,
  input  logic       user_i,
  output logic       fault_o,
  output logic       dirty_req_o
);
  logic deny;
  assign deny = (store_i ? !flg_i.wr : !flg_i.rd) || (user_i && !flg_i.usr);
  assign fault_o     = hit_i && deny;
  assign dirty_req_o = hit_i && !deny && store_i && !flg_i.dty;
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned REPL    = REPL_FIFO,
  localparam int unsigned VPN_W  = VA_W - PAGE_W,
  localparam int unsigned PPN_W  = PA_W - PAGE_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lkp_valid_i,
  input  logic [VA_W-1:0]  lkp_vaddr_i,
  input  logic             lkp_store_i,
  input  logic             lkp_user_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  output logic             prot_fault_o,
  output logic             dirty_req_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             fill_usr_i,
  input  logic             fill_dirty_i
);
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  pte_flags_t [ENTRIES-1:0]      flg_q;
  logic [ENTRIES-1:0]            vld;
  logic [ENTRIES-1:0]            match;
  logic                          any_match, hit;
  logic [IDX_W-1:0]              hit_idx, vict_idx;
  logic [VPN_W-1:0]              lkp_vpn;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign vld[g] = flg_q[g].vld;
  end

  assign lkp_vpn = lkp_vaddr_i[VA_W-1:PAGE_W];

  tlb_fa_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid_i (vld),
    .tag_i   (tag_q),
    .vpn_i   (lkp_vpn),
    .match_o (match),
    .any_o   (any_match),
    .idx_o   (hit_idx)
  );

  tlb_fa_victim #(.ENTRIES(ENTRIES), .REPL(REPL)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (vld),
    .use_i   (fill_valid_i && !flush_i),
    .idx_o   (vict_idx)
  );

  assign hit = lkp_valid_i && any_match;

  tlb_fa_prot u_prot (
    .hit_i       (hit),
    .flg_i       (flg_q[hit_idx]),
    .store_i     (lkp_store_i),
    .user_i      (lkp_user_i),
    .fault_o     (prot_fault_o),
    .dirty_req_o (dirty_req_o)
  );

  assign hit_o      = hit;
  assign paddr_o    = hit ? {ppn_q[hit_idx], lkp_vaddr_i[PAGE_W-1:0]} : '0;
  assign walk_req_o = lkp_valid_i && !any_match;
  assign walk_vpn_o = lkp_vpn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      ppn_q <= '0;
      flg_q <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) flg_q[i].vld <= 1'b0;
    end else begin
      if (dirty_req_o) flg_q[hit_idx].dty <= 1'b1;
      // fill after dirty update: a fill into the same slot wins
      if (fill_valid_i) begin
        tag_q[vict_idx] <= fill_vpn_i;
        ppn_q[vict_idx] <= fill_ppn_i;
        flg_q[vict_idx] <= '{vld: 1'b1, rd: fill_rd_i, wr: fill_wr_i,
                             usr: fill_usr_i, dty: fill_dirty_i};
      end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned PAGE_W  = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               lkp_valid_i,
  input logic [VA_W-1:0]    lkp_vaddr_i,
  input logic               lkp_store_i,
  input logic               hit_o,
  input logic [PA_W-1:0]    paddr_o,
  input logic               walk_req_o,
  input logic               prot_fault_o,
  input logic               dirty_req_o,
  input logic [ENTRIES-1:0] match_i
);
  // R1
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_i));
  // R3
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[PAGE_W-1:0] == lkp_vaddr_i[PAGE_W-1:0]);
  // R4
  hit_walk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && walk_req_o) && ((hit_o || walk_req_o) == lkp_valid_i));
  // R5
  fault_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> hit_o);
  // R6
  dirty_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_req_o |-> hit_o && lkp_store_i && !prot_fault_o);
  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);
endmodule

bind tlb_fa tlb_fa_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_vaddr_i  (lkp_vaddr_i),
  .lkp_store_i  (lkp_store_i),
  .hit_o        (hit_o),
  .paddr_o      (paddr_o),
  .walk_req_o   (walk_req_o),
  .prot_fault_o (prot_fault_o),
  .dirty_req_o  (dirty_req_o),
  .match_i      (match)
);

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
  localparam int N  = 32;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        flush, lv, lst, lus, fv, frd, fwr, fus, fd;
  logic [31:0] lva;
  logic [19:0] fvpn, fppn;
  logic        hit, wreq, flt, dreq;
  logic [31:0] pa;
  logic [19:0] wvpn;

  tlb_fa #(.ENTRIES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .lkp_valid_i(lv), .lkp_vaddr_i(lva), .lkp_store_i(lst), .lkp_user_i(lus),
    .hit_o(hit), .paddr_o(pa), .walk_req_o(wreq), .walk_vpn_o(wvpn),
    .prot_fault_o(flt), .dirty_req_o(dreq),
    .fill_valid_i(fv), .fill_vpn_i(fvpn), .fill_ppn_i(fppn),
    .fill_rd_i(frd), .fill_wr_i(fwr), .fill_usr_i(fus), .fill_dirty_i(fd)
  );

  logic        r_lv, r_fv, r_hit, r_wreq, r_flt, r_dreq;
  logic [31:0] r_lva, r_pa;
  logic [19:0] r_fvpn, r_wvpn;

  tlb_fa #(.ENTRIES(NR), .REPL(1)) uut_rnd (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(1'b0),
    .lkp_valid_i(r_lv), .lkp_vaddr_i(r_lva), .lkp_store_i(1'b0), .lkp_user_i(1'b0),
    .hit_o(r_hit), .paddr_o(r_pa), .walk_req_o(r_wreq), .walk_vpn_o(r_wvpn),
    .prot_fault_o(r_flt), .dirty_req_o(r_dreq),
    .fill_valid_i(r_fv), .fill_vpn_i(r_fvpn), .fill_ppn_i(r_fvpn),
    .fill_rd_i(1'b1), .fill_wr_i(1'b1), .fill_usr_i(1'b1), .fill_dirty_i(1'b0)
  );

  int checks = 0;
  int errors = 0;

  // bench model of the array
  logic        m_v[N], m_rd[N], m_wr[N], m_us[N], m_d[N];
  logic [19:0] m_vpn[N], m_ppn[N];
  int          m_ptr;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic logic m_deny(int i, logic st, logic us);
    return (st ? !m_wr[i] : !m_rd[i]) || (us && !m_us[i]);
  endfunction

  // one cycle: drive at negedge, compare, advance model as the edge will
  task automatic step(logic l_v, logic [31:0] va, logic st, logic us,
                      logic f_v, logic [19:0] vpn, logic [19:0] ppn,
                      logic p_rd, logic p_wr, logic p_us, logic p_d, logic fl);
    int i, vi;
    logic ehit, eflt, edrq;
    @(negedge clk);
    lv = l_v; lva = va; lst = st; lus = us;
    fv = f_v; fvpn = vpn; fppn = ppn; frd = p_rd; fwr = p_wr; fus = p_us; fd = p_d;
    flush = fl;
    #1;
    i    = m_find(va[31:12]);
    ehit = l_v && (i >= 0);
    eflt = ehit && m_deny(i, st, us);
    edrq = ehit && !eflt && st && !m_d[i];
    chk("R1", "hit", 32'(hit), 32'(ehit));
    chk("R3", "paddr", pa, ehit ? {m_ppn[i], va[11:0]} : 32'h0);
    chk("R4", "walk_req", 32'(wreq), 32'(l_v && !ehit));
    if (l_v && !ehit) chk("R4", "walk_vpn", 32'(wvpn), 32'(va[31:12]));
    chk("R5", "fault", 32'(flt), 32'(eflt));
    chk("R6", "dirty_req", 32'(dreq), 32'(edrq));
    if (fl) begin
      for (int k = 0; k < N; k++) m_v[k] = 1'b0;
    end else begin
      if (edrq) m_d[i] = 1'b1;
      if (f_v) begin
        vi = -1;
        for (int k = N - 1; k >= 0; k--) if (!m_v[k]) vi = k;
        if (vi < 0) begin
          vi = m_ptr;
          m_ptr = (m_ptr + 1) % N;
        end
        m_v[vi] = 1'b1; m_vpn[vi] = vpn; m_ppn[vi] = ppn;
        m_rd[vi] = p_rd; m_wr[vi] = p_wr; m_us[vi] = p_us; m_d[vi] = p_d;
      end
    end
  endtask

  task automatic look(logic [19:0] vpn, logic [11:0] off, logic st, logic us);
    step(1'b1, {vpn, off}, st, us, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic p_rd, logic p_wr,
                      logic p_us, logic p_d);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, vpn, ppn, p_rd, p_wr, p_us, p_d, 1'b0);
  endtask

  task automatic rnd_fill(logic [19:0] vpn);
    @(negedge clk); r_lv = 1'b0; r_fv = 1'b1; r_fvpn = vpn;
    @(negedge clk); r_fv = 1'b0;
  endtask

  task automatic rnd_probe(logic [19:0] vpn, output logic h);
    @(negedge clk); r_lv = 1'b1; r_lva = {vpn, 12'h0}; #1; h = r_hit;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    logic h;
    logic [19:0] vp;
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) begin
      m_v[k] = 0; m_rd[k] = 0; m_wr[k] = 0; m_us[k] = 0; m_d[k] = 0;
      m_vpn[k] = '0; m_ppn[k] = '0;
    end
    m_ptr = 0;
    flush = 0; lv = 0; lva = 0; lst = 0; lus = 0;
    fv = 0; fvpn = 0; fppn = 0; frd = 0; fwr = 0; fus = 0; fd = 0;
    r_lv = 0; r_lva = 0; r_fv = 0; r_fvpn = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "hit in reset", 32'(hit), 32'h0);
    chk("R11", "walk in reset", 32'(wreq), 32'h0);
    rst_n = 1'b1;

    // R11: empty after reset
    look(20'h00010, 12'h004, 1'b0, 1'b0);
    chk("R11", "miss after reset", 32'(wreq), 32'h1);

    // R7: fill every slot; nothing may be lost
    for (int k = 0; k < N; k++) fill(20'h00100 + 20'(k), 20'h80000 + 20'(k), 1, 1, 1, 0);
    cnt = 0;
    for (int k = 0; k < N; k++) begin
      look(20'h00100 + 20'(k), 12'(k * 3), 1'b0, 1'b1);
      if (hit) cnt++;
    end
    chk("R7", "resident after fill", 32'(cnt), 32'(N));

    // R8: round-robin eviction starting at slot 0
    fill(20'h00200, 20'h90000, 1, 1, 1, 0);
    look(20'h00100, 12'h0, 1'b0, 1'b0);
    chk("R8", "slot0 evicted", 32'(hit), 32'h0);
    look(20'h00101, 12'h0, 1'b0, 1'b0);
    chk("R8", "slot1 kept", 32'(hit), 32'h1);
    fill(20'h00201, 20'h90001, 1, 1, 1, 0);
    look(20'h00101, 12'h0, 1'b0, 1'b0);
    chk("R8", "slot1 evicted", 32'(hit), 32'h0);
    look(20'h00200, 12'hABC, 1'b0, 1'b0);
    chk("R2", "new fill visible", pa, 32'h90000ABC);

    // R10: flush beats a simultaneous fill
    step(1'b0, '0, 0, 0, 1'b1, 20'h00300, 20'h12345, 1, 1, 1, 0, 1'b1);
    look(20'h00300, 12'h0, 1'b0, 1'b0);
    chk("R10", "fill dropped by flush", 32'(hit), 32'h0);
    look(20'h00102, 12'h0, 1'b0, 1'b0);
    chk("R10", "old page flushed", 32'(hit), 32'h0);

    // R5: permission grid (vpn encodes {rd,wr,usr} in low bits)
    for (int p = 0; p < 8; p++) fill(20'h00400 + 20'(p), 20'h40000 + 20'(p), p[2], p[1], p[0], 1'b1);
    for (int p = 0; p < 8; p++)
      for (int a = 0; a < 4; a++) begin
        look(20'h00400 + 20'(p), 12'h010, a[1], a[0]);
        chk("R5", "grid fault", 32'(flt),
            32'((a[1] ? !p[1] : !p[2]) || (a[0] && !p[0])));
      end

    // R6: first store to clean page requests update, second does not
    fill(20'h00500, 20'h50000, 1, 1, 1, 0);
    look(20'h00500, 12'h0, 1'b1, 1'b0);
    chk("R6", "first store", 32'(dreq), 32'h1);
    look(20'h00500, 12'h0, 1'b1, 1'b0);
    chk("R6", "second store", 32'(dreq), 32'h0);
    fill(20'h00501, 20'h50001, 1, 0, 1, 0);
    look(20'h00501, 12'h0, 1'b1, 1'b0);
    chk("R6", "faulting store", 32'(dreq), 32'h0);

    // random phase: pool larger than the array
    for (int it = 0; it < 3000; it++) begin
      vp = 20'h03000 + 20'($urandom_range(0, 47));
      if ($urandom_range(0, 99) == 0)
        step(1'b0, '0, 0, 0, 1'b0, '0, '0, 0, 0, 0, 0, 1'b1);
      else if (m_find(vp) < 0)
        fill(vp, 20'($urandom), 1'($urandom_range(0, 7) != 0), 1'($urandom),
             1'($urandom), 1'($urandom));
      else
        look(vp, 12'($urandom), 1'($urandom), 1'($urandom));
    end

    // R9: LFSR instance, invalid-first then single eviction per fill
    for (int k = 0; k < NR; k++) rnd_fill(20'h00700 + 20'(k));
    cnt = 0;
    for (int k = 0; k < NR; k++) begin rnd_probe(20'h00700 + 20'(k), h); if (h) cnt++; end
    chk("R9", "lfsr fill no loss", 32'(cnt), 32'(NR));
    for (int e = 0; e < 6; e++) begin
      rnd_fill(20'h00800 + 20'(e));
      cnt = 0;
      for (int k = 0; k < NR; k++) begin rnd_probe(20'h00700 + 20'(k), h); if (h) cnt++; end
      for (int k = 0; k <= e; k++) begin rnd_probe(20'h00800 + 20'(k), h); if (h) cnt++; end
      chk("R9", "lfsr resident count", 32'(cnt), 32'(NR));
      rnd_probe(20'h00800 + 20'(e), h);
      chk("R9", "lfsr new page", 32'(h), 32'h1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule